// File: doc/BRIEF.md
# CAN Controller Host Register Block

This block is the host-side control and status register set of a CAN controller. Software uses it to choose the operating mode, to program the bit timing, to pick which events raise an interrupt, and to read the bus error condition and the error counters. The protocol engine is not part of this block. It appears only as input ports that carry its two error-state fields, its two error counters and one-cycle event pulses. The block hands the engine its bit-timing and mode configuration and the init and sleep acknowledges.

Entering init mode, or leaving it, is a handshake. Software writes a request bit and then polls an acknowledge bit. The acknowledge takes the requested value a fixed number of clocks later. Bit timing, listen-only and loopback can be changed only while init is acknowledged. When init is not acknowledged, a write to those bits is dropped. The error state that the engine reports is tracked on its own path and is never cleared by init mode; no soft reset exists. Event flags are cleared by writing one to them. Any change in either error-state field sets a state-change flag. The interrupt line is the OR of the flags, each gated by its enable.

The bus is a word-indexed register port with a write strobe. Reads are combinational. Word 0 is control, 1 is interrupt enable, 2 is status, 3 is error counters and 4 is timebase.

Top module: `can_ctrl_regs`

## Requirements
- R1: Reset state: control reads 0x0000_8101 (init requested and acknowledged, enable bit 15 set, everything else 0), interrupt enable reads 0, status reads 0 when the engine reports state 0, and irq is low.
- R2: The init acknowledge (control bit 8, port init_ack) takes the value of the init request (control bit 0) on the ACK_DLY-th rising edge after the edge that stored the request. The sleep acknowledge (bit 9, port sleep_ack) follows the sleep request (bit 1) in the same way. The request bits can be written at any time.
- R3: While init is acknowledged, a control write stores the bit-timing fields and reads them back. The fields are prescaler-1 in [21:16], jump width-1 in [23:22], segment 1-1 in [27:24], segment 2-1 in [30:28] and triple sampling in bit 31. The same write stores listen-only (bit 12) and loopback (bit 13). All of these appear on the cfg_* ports.
- R4: While init is not acknowledged, a control write leaves bits [31:16], 12 and 13 unchanged.
- R5: Control bit 15 always reads 1. Bits 8 and 9 show only the acknowledges, and writes to them have no effect.
- R6: A one-cycle event pulse sets its status flag on the next edge. The positions are receive 16, overrun 17, timeout 23, transmit 24 and error 25.
- R7: Writing status with a 1 in a flag position clears that flag, and a 0 leaves it as it was. An event on the same edge as a clear wins, and the flag stays set.
- R8: Status shows the transmit error state in [19:18] and the receive error state in [21:20], one edge after the input. The encoding is 0 active, 1 warning, 2 passive, 3 bus-off.
- R9: The state-change flag (status bit 22) sets on any edge where either state input differs from the state shown.
- R10: Entering or leaving init mode does not alter the error-state fields or the error counters.
- R11: irq is high exactly when a set flag has its enable set. Enable positions are receive 0, overrun 1, state change 6, timeout 7, transmit 16 and error 17. Only these bits are stored, so interrupt enable reads back the written value AND 0x0003_00C3.
- R12: Word 3 reads the receive error count in [7:0] and the transmit error count in [23:16], with zeros elsewhere. Word 4 reads the TIMEBASE parameter. Words 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word index for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| eng_tx_state | input | 2 | Transmit error state from the engine |
| eng_rx_state | input | 2 | Receive error state from the engine |
| eng_rx_errcnt | input | 8 | Receive error counter |
| eng_tx_errcnt | input | 8 | Transmit error counter |
| ev_rx | input | 1 | Frame received pulse |
| ev_ovr | input | 1 | Receive overrun pulse |
| ev_tout | input | 1 | Receive timeout pulse |
| ev_tx | input | 1 | Transmit done pulse |
| ev_err | input | 1 | Bus error pulse |
| cfg_prescale | output | 6 | Prescaler minus one |
| cfg_sjw | output | 2 | Jump width minus one |
| cfg_tseg1 | output | 4 | Segment 1 minus one |
| cfg_tseg2 | output | 3 | Segment 2 minus one |
| cfg_triple | output | 1 | Triple sampling |
| cfg_listen | output | 1 | Listen-only mode |
| cfg_loopback | output | 1 | Loopback mode |
| init_ack | output | 1 | Init mode acknowledged |
| sleep_ack | output | 1 | Sleep acknowledged |
| irq | output | 1 | Interrupt request |

## Verification
The bit-timing path is driven with one directed pattern that sets every field to a distinct value. Half of that pattern is written while init is acknowledged and half while it is not, which separates the write gate from field placement. The acknowledge delay is counted edge by edge after each request change, and this exposes an off-by-one in the handshake counter. The flag logic is driven by random event pulses, random state changes and random write-one-to-clear data under a random enable mask. Against a bench model, this separates set from clear priority, wrong bit positions and missed state changes. Directed runs cover a clear and an event on the same edge, a zero write, and the error state held across an init entry.

// File: rtl/can_regs_pkg.sv
package can_regs_pkg;
  localparam int REG_W  = 32;
  localparam int IDX_W  = $clog2(REG_W);
  localparam int NFLAG  = 6;
  localparam int ECNT_W = 8;

  // flag slots, shared by status and enable layouts
  localparam int FL_RX   = 0;
  localparam int FL_OVR  = 1;
  localparam int FL_CSC  = 2;
  localparam int FL_TOUT = 3;
  localparam int FL_TX   = 4;
  localparam int FL_ERR  = 5;

  // word indices
  localparam int A_CTRL  = 0;
  localparam int A_IE    = 1;
  localparam int A_STAT  = 2;
  localparam int A_ECNT  = 3;
  localparam int A_TBASE = 4;

  // control bit positions
  localparam int CB_INIT_AK = 8;
  localparam int CB_SLP_AK  = 9;
  localparam int CB_ENABLE  = 15;
  localparam int ST_TX_LSB  = 18;
  localparam int ST_RX_LSB  = 20;

  // writable control bits: request bits always, the rest only in init
  localparam logic [REG_W-1:0] CTRL_WMASK_RUN  = 32'h0000_0003;
  localparam logic [REG_W-1:0] CTRL_WMASK_INIT = 32'hFFFF_3003;
  localparam logic [REG_W-1:0] IE_MASK         = 32'h0003_00C3;

  function automatic logic [IDX_W-1:0] flag_stat_pos(input int i);
    case (i)
      FL_RX:   return IDX_W'(16);
      FL_OVR:  return IDX_W'(17);
      FL_CSC:  return IDX_W'(22);
      FL_TOUT: return IDX_W'(23);
      FL_TX:   return IDX_W'(24);
      default: return IDX_W'(25);
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] flag_ie_pos(input int i);
    case (i)
      FL_RX:   return IDX_W'(0);
      FL_OVR:  return IDX_W'(1);
      FL_CSC:  return IDX_W'(6);
      FL_TOUT: return IDX_W'(7);
      FL_TX:   return IDX_W'(16);
      default: return IDX_W'(17);
    endcase
  endfunction

  // gather the flag slots out of a register word
  function automatic logic [NFLAG-1:0] pick_flags(input logic [REG_W-1:0] w,
                                                  input logic use_ie);
    logic [NFLAG-1:0] f;
    for (int i = 0; i < NFLAG; i++)
      f[i] = w[use_ie ? flag_ie_pos(i) : flag_stat_pos(i)];
    return f;
  endfunction

  // scatter flag slots into a register word
  function automatic logic [REG_W-1:0] place_flags(input logic [NFLAG-1:0] f,
                                                   input logic use_ie);
    logic [REG_W-1:0] w;
    w = '0;
    for (int i = 0; i < NFLAG; i++)
      w[use_ie ? flag_ie_pos(i) : flag_stat_pos(i)] = f[i];
    return w;
  endfunction

  // masked merge of a control write, gated by the init acknowledge
  function automatic logic [REG_W-1:0] ctrl_merge(input logic [REG_W-1:0] q,
                                                  input logic [REG_W-1:0] d,
                                                  input logic in_init);
    logic [REG_W-1:0] m;
    m = in_init ? CTRL_WMASK_INIT : CTRL_WMASK_RUN;
    return (q & ~m) | (d & m);
  endfunction
endpackage

// File: rtl/can_mode_handshake.sv
module can_mode_handshake #(
  parameter int   ACK_DLY = 4,
  parameter logic RST_ACK = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic ack
);
  localparam int CW = (ACK_DLY < 2) ? 1 : $clog2(ACK_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(ACK_DLY - 1);

  logic [CW-1:0] cnt_q;
  logic          pending;
  logic          expire;

  assign pending = (req != ack);
  assign expire  = pending && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack   <= RST_ACK;
      cnt_q <= '0;
    end else if (!pending) begin
      cnt_q <= '0;
    end else if (expire) begin
      ack   <= req;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack) |-> $past(req != ack));
endmodule

// File: rtl/can_ctrl_word.sv
module can_ctrl_word
  import can_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             in_init,
  output logic [REG_W-1:0] ctrl_q
);
  logic [REG_W-1:0] ctrl_d;

  assign ctrl_d = ctrl_merge(ctrl_q, wdata, in_init);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= 32'h0000_0001;
    else if (wr) ctrl_q <= ctrl_d;
  end

  // R4
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !in_init) |=> ((ctrl_q & ~CTRL_WMASK_RUN) == $past(ctrl_q & ~CTRL_WMASK_RUN)));

  // R3
  init_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && in_init) |=> ((ctrl_q & CTRL_WMASK_INIT) == $past(wdata & CTRL_WMASK_INIT)));
endmodule

// File: rtl/can_status_flags.sv
module can_status_flags
  import can_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] ev_in,
  input  logic [NFLAG-1:0] clr,
  input  logic [1:0]       tx_state_in,
  input  logic [1:0]       rx_state_in,
  output logic [NFLAG-1:0] flags_q,
  output logic [1:0]       tx_state_q,
  output logic [1:0]       rx_state_q,
  output logic             state_change
);
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] flags_d;

  assign state_change = ({tx_state_in, rx_state_in} != {tx_state_q, rx_state_q});

  always_comb begin
    set_vec         = ev_in;
    set_vec[FL_CSC] = ev_in[FL_CSC] | state_change;
    flags_d         = (flags_q & ~clr) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q    <= '0;
      tx_state_q <= '0;
      rx_state_q <= '0;
    end else begin
      flags_q    <= flags_d;
      tx_state_q <= tx_state_in;
      rx_state_q <= rx_state_in;
    end
  end

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~set_vec) != '0) |=> ((flags_q & $past(clr & ~set_vec)) == '0));

  // R9
  csc_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_change |=> flags_q[FL_CSC]);

  // R8
  state_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_change |=> ({tx_state_q, rx_state_q} == $past({tx_state_in, rx_state_in})));
endmodule

// File: rtl/can_ctrl_regs.sv
module can_ctrl_regs
  import can_regs_pkg::*;
#(
  parameter int          ADDR_W   = 3,
  parameter int          ACK_DLY  = 4,
  parameter logic [31:0] TIMEBASE = 32'd40_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [1:0]        eng_tx_state,
  input  logic [1:0]        eng_rx_state,
  input  logic [7:0]        eng_rx_errcnt,
  input  logic [7:0]        eng_tx_errcnt,
  input  logic              ev_rx,
  input  logic              ev_ovr,
  input  logic              ev_tout,
  input  logic              ev_tx,
  input  logic              ev_err,
  output logic [5:0]        cfg_prescale,
  output logic [1:0]        cfg_sjw,
  output logic [3:0]        cfg_tseg1,
  output logic [2:0]        cfg_tseg2,
  output logic              cfg_triple,
  output logic              cfg_listen,
  output logic              cfg_loopback,
  output logic              init_ack,
  output logic              sleep_ack,
  output logic              irq
);
  localparam int NMODE = 2;

  logic              wr_ctrl, wr_ie, wr_stat;
  logic [REG_W-1:0]  ctrl_q;
  logic [REG_W-1:0]  ie_q;
  logic [NMODE-1:0]  mode_ack;
  logic [NFLAG-1:0]  ev_vec, clr_vec, flags_q, ie_flags;
  logic [1:0]        tx_state_q, rx_state_q;
  logic              state_change;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign wr_ie   = bus_wr && (bus_addr == ADDR_W'(A_IE));
  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(A_STAT));

  // control word with gated timing fields
  can_ctrl_word u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_ctrl),
    .wdata   (bus_wdata),
    .in_init (init_ack),
    .ctrl_q  (ctrl_q)
  );

  // init (slot 0) and sleep (slot 1) request/acknowledge pairs
  for (genvar g = 0; g < NMODE; g++) begin : g_hs
    can_mode_handshake #(
      .ACK_DLY (ACK_DLY),
      .RST_ACK ((g == 0) ? 1'b1 : 1'b0)
    ) u_hs (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (ctrl_q[g]),
      .ack   (mode_ack[g])
    );
  end

  assign init_ack  = mode_ack[0];
  assign sleep_ack = mode_ack[1];

  assign cfg_prescale = ctrl_q[21:16];
  assign cfg_sjw      = ctrl_q[23:22];
  assign cfg_tseg1    = ctrl_q[27:24];
  assign cfg_tseg2    = ctrl_q[30:28];
  assign cfg_triple   = ctrl_q[31];
  assign cfg_listen   = ctrl_q[12];
  assign cfg_loopback = ctrl_q[13];

  // interrupt enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie_q <= '0;
    else if (wr_ie) ie_q <= bus_wdata & IE_MASK;
  end

  always_comb begin
    ev_vec          = '0;
    ev_vec[FL_RX]   = ev_rx;
    ev_vec[FL_OVR]  = ev_ovr;
    ev_vec[FL_TOUT] = ev_tout;
    ev_vec[FL_TX]   = ev_tx;
    ev_vec[FL_ERR]  = ev_err;
    clr_vec         = wr_stat ? pick_flags(bus_wdata, 1'b0) : '0;
  end

  can_status_flags u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_in        (ev_vec),
    .clr          (clr_vec),
    .tx_state_in  (eng_tx_state),
    .rx_state_in  (eng_rx_state),
    .flags_q      (flags_q),
    .tx_state_q   (tx_state_q),
    .rx_state_q   (rx_state_q),
    .state_change (state_change)
  );

  assign ie_flags = pick_flags(ie_q, 1'b1);
  assign irq      = |(flags_q & ie_flags);

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(A_CTRL): begin
        bus_rdata             = ctrl_q;
        bus_rdata[CB_INIT_AK] = init_ack;
        bus_rdata[CB_SLP_AK]  = sleep_ack;
        bus_rdata[CB_ENABLE]  = 1'b1;
      end
      ADDR_W'(A_IE): bus_rdata = ie_q;
      ADDR_W'(A_STAT): begin
        bus_rdata                          = place_flags(flags_q, 1'b0);
        bus_rdata[ST_TX_LSB+1:ST_TX_LSB]   = tx_state_q;
        bus_rdata[ST_RX_LSB+1:ST_RX_LSB]   = rx_state_q;
      end
      ADDR_W'(A_ECNT): begin
        bus_rdata[ECNT_W-1:0]  = eng_rx_errcnt;
        bus_rdata[16+ECNT_W-1:16] = eng_tx_errcnt;
      end
      ADDR_W'(A_TBASE): bus_rdata = TIMEBASE;
      default: bus_rdata = '0;
    endcase
  end

  // R11
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_change && ie_q[6]) |=> irq);
endmodule

// File: tb/test_can_ctrl_regs.sv
module test_can_ctrl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 3;
  localparam int ACK_DLY    = 4;
  localparam logic [31:0] TIMEBASE = 32'd40_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0] eng_tx_state = '0, eng_rx_state = '0;
  logic [7:0] eng_rx_errcnt = '0, eng_tx_errcnt = '0;
  logic ev_rx = 0, ev_ovr = 0, ev_tout = 0, ev_tx = 0, ev_err = 0;
  logic [5:0] cfg_prescale;
  logic [1:0] cfg_sjw;
  logic [3:0] cfg_tseg1;
  logic [2:0] cfg_tseg2;
  logic cfg_triple, cfg_listen, cfg_loopback, init_ack, sleep_ack, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_ctrl_regs #(.ADDR_W(ADDR_W), .ACK_DLY(ACK_DLY), .TIMEBASE(TIMEBASE)) i_can_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_tx_state(eng_tx_state), .eng_rx_state(eng_rx_state),
    .eng_rx_errcnt(eng_rx_errcnt), .eng_tx_errcnt(eng_tx_errcnt),
    .ev_rx(ev_rx), .ev_ovr(ev_ovr), .ev_tout(ev_tout), .ev_tx(ev_tx), .ev_err(ev_err),
    .cfg_prescale(cfg_prescale), .cfg_sjw(cfg_sjw), .cfg_tseg1(cfg_tseg1),
    .cfg_tseg2(cfg_tseg2), .cfg_triple(cfg_triple), .cfg_listen(cfg_listen),
    .cfg_loopback(cfg_loopback), .init_ack(init_ack), .sleep_ack(sleep_ack), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a); bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = ADDR_W'(a);
    #1 d = bus_rdata;
  endtask

  // count edges until init_ack reaches the wanted value
  task automatic wait_ack(input bit want_sleep, input logic val, output int n);
    n = 0;
    while (((want_sleep ? sleep_ack : init_ack) !== val) && n < 40) begin
      @(posedge clk); #1; n++;
    end
  endtask

  // bench view of the interrupt mapping
  function automatic logic exp_irq(input logic [31:0] st, input logic [31:0] ie);
    return (st[16] & ie[0]) | (st[17] & ie[1]) | (st[22] & ie[6]) |
           (st[23] & ie[7]) | (st[24] & ie[16]) | (st[25] & ie[17]);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, exp_st, ie_val, clr, set_w;
    logic [1:0] tx_s, rx_s;
    int n;
    void'($urandom(32'd12345));

    #(CLK_PERIOD * 3);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd_reg(0, v); check("R1 ctrl", v, 32'h0000_8101);
    rd_reg(1, v); check("R1 ie", v, 32'h0);
    rd_reg(2, v); check("R1 status", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R3 timing write in init
    wr_reg(0, 32'hA5C3_3101);
    rd_reg(0, v); check("R3 ctrl readback", v, 32'hA5C3_B101);
    check("R3 prescale", {26'b0, cfg_prescale}, (32'hA5C3_0000 >> 16) & 32'h3F);
    check("R3 sjw", {30'b0, cfg_sjw}, (32'hA5C3_0000 >> 22) & 32'h3);
    check("R3 tseg1", {28'b0, cfg_tseg1}, (32'hA5C3_0000 >> 24) & 32'hF);
    check("R3 tseg2", {29'b0, cfg_tseg2}, (32'hA5C3_0000 >> 28) & 32'h7);
    check("R3 triple/listen/loop", {29'b0, cfg_triple, cfg_listen, cfg_loopback}, 32'h7);

    // R2 leave init: ack drops after ACK_DLY edges
    wr_reg(0, 32'hA5C3_3100);
    wait_ack(1'b0, 1'b0, n);
    check("R2 init ack delay", n, ACK_DLY);

    // R4 timing ignored while running; R5 bit 15 and ack bits
    wr_reg(0, 32'h1234_0300);
    rd_reg(0, v); check("R4 R5 ctrl after run write", v, 32'hA5C3_B000);
    check("R4 cfg_listen kept", {31'b0, cfg_listen}, 32'h1);

    // R2 sleep handshake while running
    wr_reg(0, 32'h0000_0002);
    wait_ack(1'b1, 1'b1, n);
    check("R2 sleep ack delay", n, ACK_DLY);
    rd_reg(0, v); check("R2 R4 ctrl in sleep", v, 32'hA5C3_B202);
    wr_reg(0, 32'h0000_0000);
    wait_ack(1'b1, 1'b0, n);
    check("R2 sleep release delay", n, ACK_DLY);

    // R8 error state, R12 counters, timebase, unmapped
    @(negedge clk);
    eng_tx_state = 2'd2; eng_rx_state = 2'd3;
    eng_rx_errcnt = 8'h5A; eng_tx_errcnt = 8'hC7;
    rd_reg(2, v); check("R8 state fields", v & 32'h003C_0000, 32'h0038_0000);
    check("R9 csc set", {31'b0, v[22]}, 32'h1);
    rd_reg(3, v); check("R12 errcnt", v, 32'h00C7_005A);
    rd_reg(4, v); check("R12 timebase", v, TIMEBASE);
    rd_reg(6, v); check("R12 unmapped", v, 32'h0);

    // R10 enter init, state kept
    wr_reg(0, 32'h0000_0001);
    wait_ack(1'b0, 1'b1, n);
    check("R10 init ack delay", n, ACK_DLY);
    rd_reg(2, v); check("R10 state after init", v & 32'h003C_0000, 32'h0038_0000);
    rd_reg(3, v); check("R10 errcnt after init", v, 32'h00C7_005A);
    rd_reg(0, v); check("R10 ctrl timing kept", v, 32'hA5C3_B101);

    // R11 enable readback mask
    wr_reg(1, 32'hFFFF_FFFF);
    rd_reg(1, v); check("R11 ie mask", v, 32'h0003_00C3);

    // R7 clear all, then directed priority and zero write
    wr_reg(2, 32'hFFFF_FFFF);
    rd_reg(2, v); check("R7 clear all", v & 32'h03C3_0000, 32'h0);
    check("R11 irq low", {31'b0, irq}, 32'h0);
    @(negedge clk);
    bus_addr = ADDR_W'(2); bus_wdata = 32'h0001_0000; bus_wr = 1'b1; ev_rx = 1'b1;
    @(posedge clk); #1; bus_wr = 1'b0; ev_rx = 1'b0;
    #1 check("R7 set wins", {31'b0, bus_rdata[16]}, 32'h1);
    check("R11 irq from rx", {31'b0, irq}, 32'h1);
    wr_reg(2, 32'h0);
    rd_reg(2, v); check("R7 zero write", {31'b0, v[16]}, 32'h1);
    wr_reg(2, 32'h0001_0000);
    rd_reg(2, v); check("R7 clear rx", {31'b0, v[16]}, 32'h0);

    // random phase: R6 R7 R8 R9 R11
    ie_val = $urandom() & 32'h0003_00C3;
    wr_reg(1, ie_val);
    exp_st = 32'h0;
    tx_s = eng_tx_state; rx_s = eng_rx_state;
    for (int k = 0; k < 500; k++) begin
      logic [4:0] ev;
      logic do_wr, chg;
      logic [1:0] ntx, nrx;
      if (k % 100 == 99) begin
        ie_val = $urandom() & 32'h0003_00C3;
        wr_reg(1, ie_val);
      end
      ev    = 5'($urandom() & $urandom());
      do_wr = ($urandom() % 4) == 0;
      clr   = $urandom();
      chg   = ($urandom() % 6) == 0;
      ntx = chg ? 2'($urandom()) : tx_s;
      nrx = chg ? 2'($urandom()) : rx_s;
      @(negedge clk);
      bus_addr = ADDR_W'(2); bus_wdata = clr; bus_wr = do_wr;
      {ev_rx, ev_ovr, ev_tout, ev_tx, ev_err} = ev;
      eng_tx_state = ntx; eng_rx_state = nrx;
      @(posedge clk); #1;
      bus_wr = 1'b0; {ev_rx, ev_ovr, ev_tout, ev_tx, ev_err} = 5'b0;
      set_w = 32'h0;
      set_w[16] = ev[4]; set_w[17] = ev[3]; set_w[23] = ev[2];
      set_w[24] = ev[1]; set_w[25] = ev[0];
      set_w[22] = (ntx != tx_s) || (nrx != rx_s);
      exp_st = (exp_st & ~(do_wr ? (clr & 32'h03C3_0000) : 32'h0)) | set_w;
      tx_s = ntx; rx_s = nrx;
      #1;
      check("R6 R7 R8 R9 random status", bus_rdata,
            exp_st | (32'(tx_s) << 18) | (32'(rx_s) << 20));
      check("R11 random irq", {31'b0, irq}, {31'b0, exp_irq(exp_st, ie_val)});
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule